// File: doc/BRIEF.md
# Instruction Byte Predecode Annotator

This block sits where raw code bytes leave the prefetch buffer. Each cycle it takes a window of sixteen bytes and tags every byte, in that same cycle, with four pieces of information. The tags say whether the byte begins an instruction, whether it ends one, and whether it is an opcode byte. The fourth tag is a micro-operation count. The tags are stored next to the bytes, so a later decoder can find every instruction boundary in a line at once. It does not have to work out lengths one instruction after another.

Only a fixed subset of the variable-length encoding is recognised. That subset covers prefix bytes, single-byte opcodes, escape-led two-byte opcodes, a ModRM byte with a displacement selected by its mode field, and 8- or 32-bit immediates. An instruction that is cut by the window edge is resumed in the next valid window through a small registered scan state. A restart input marks a window that opens a fresh stream, for example at a branch target. Lengths are limited to fifteen bytes.

Top module: `predec_annotator`

## Requirements
- R1: The tag outputs depend on the inputs of the current cycle only through combinational logic. When `win_valid_i` is low, every tag output is zero.
- R2: The bytes 26, 2E, 36, 3E, 64, 65, 66, 67, F0, F2 and F3 (hex) are prefixes when they appear before the opcode. A prefix gets no opcode flag and a count of zero. A prefix in the first position of an instruction still gets the start flag.
- R3: Lane k is the byte at `win_bytes_i[8k+7:8k]`. Within a valid window, a byte carries the start flag exactly when it is the first byte of an instruction, and the end flag exactly when it is the last byte. A one-byte instruction carries both. Lane k+1 starts exactly when lane k ends.
- R4: The opcode flag is set on the single opcode byte, or on both the 0F escape byte and the byte that follows it. It is clear on prefix, ModRM, displacement and immediate bytes.
- R5: The count is 2 bits per lane at `uops_o[2k+1:2k]`. It is 1 or 2 for that many operations, and 3 means a microcoded sequence. It sits on the last opcode byte only and is 0 on every other byte, including the 0F escape byte.
- R6: One-byte opcode rules (hex, all count 1 unless given). Below 40, low three bits 0-3 take ModRM, 4 takes imm8, 5 takes imm32. 70-7F and EB take imm8. B0-B7 take imm8. B8-BF and E9 take imm32. 88-8B take ModRM. 80 and 83 take ModRM plus imm8, count 2. 81 takes ModRM plus imm32, count 2. E8 takes imm32, count 2. C3 has count 2. CD takes imm8, count 3. Every other non-prefix byte except 0F is a one-byte instruction.
- R7: Two-byte opcode rules (second byte, hex). 80-8F take imm32 and no ModRM. A2 has no operands and count 3. AF takes ModRM with count 2. Every other second byte takes ModRM with count 1.
- R8: A ModRM byte is followed by displacement bytes chosen by its bits 7:6. The value 01 gives one byte, 10 gives four, and 00 or 11 give none. The immediate comes after the displacement.
- R9: An instruction that is still open at lane 15 continues in lane 0 of the next valid window without restart. Cycles with `win_valid_i` low do not change the carried state, whatever the other inputs do.
- R10: With `restart_i` high in a valid window, lane 0 starts a new instruction and any open instruction is dropped. `restart_i` has no effect while `win_valid_i` is low.
- R11: If an instruction has not ended by its 15th byte, that byte is given the end flag and `overlong_o` is set on it. The next byte starts a new instruction. `overlong_o` is never set on any other byte.
- R12: After reset the carried state is idle, so the first valid window starts an instruction at lane 0 even without restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_valid_i | input | 1 | Window bytes are present this cycle |
| restart_i | input | 1 | Window begins a new instruction stream at lane 0 |
| win_bytes_i | input | 128 | Sixteen code bytes, lane k at bits 8k+7:8k |
| start_o | output | 16 | Per-lane start-of-instruction flag |
| end_o | output | 16 | Per-lane end-of-instruction flag |
| opc_o | output | 16 | Per-lane opcode-byte flag |
| uops_o | output | 32 | Per-lane 2-bit operation count, lane k at bits 2k+1:2k |
| overlong_o | output | 16 | Per-lane flag: instruction cut at the 15-byte limit |

## Verification
Every first byte value, and every second byte after the escape, is swept with ModRM mode fields that rotate through all four values. A wrong table entry or displacement rule shows up as start and end marks moving in the lanes that follow. Long random streams with idle gaps, junk bytes and stray restarts while the window is invalid cover the carry across windows. If the design lost or reset its carried state, the first lanes of a window would be mis-tagged. Runs of fifteen or more prefixes, placed both inside one window and across a window edge, cover the length limit. A design that miscounted there would cut one byte early or late, or raise the overflow flag on a legal 15-byte instruction. A restart after a window that ends on an unfinished immediate shows whether stale operand counts leak into the new stream.

// File: rtl/predec_pkg.sv
// Package: shared constants and types for the predecode annotator.
// Assumes 8-bit code bytes and a 15-byte maximum instruction length.
package predec_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAX_INSN  = 15;
    localparam int LEN_W     = $clog2(MAX_INSN + 1);
    localparam int CNT_W     = 4;   // holds displacement plus immediate bytes (up to 8)
    localparam int IMM_W     = 3;   // holds 0, 1 or 4
    localparam int UOP_W     = 2;
    localparam logic [BYTE_W-1:0] ESC_BYTE = 8'h0F;

    // Where the scan is inside the current instruction
    typedef enum logic [1:0] {
        PH_OPC   = 2'd0,   // expecting a prefix or the first opcode byte
        PH_ESC   = 2'd1,   // expecting the byte after the escape
        PH_MODRM = 2'd2,   // expecting a ModRM byte
        PH_TAIL  = 2'd3    // inside displacement / immediate bytes
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [LEN_W-1:0]   len;   // bytes of this instruction already seen
        logic [CNT_W-1:0]   rem;   // tail bytes still to come, this one included
        logic [IMM_W-1:0]   imm;   // immediate bytes owed after ModRM
    } scan_t;

    localparam scan_t SCAN_IDLE = '{phase: PH_OPC, len: '0, rem: '0, imm: '0};

    // Operand shape of one opcode
    typedef struct packed {
        logic               modrm;
        logic [IMM_W-1:0]   imm;
        logic [UOP_W-1:0]   uops;
    } opcls_t;

    // Tag bits attached to one byte
    typedef struct packed {
        logic               start;
        logic               fin;
        logic               opc;
        logic [UOP_W-1:0]   uops;
    } tag_t;
endpackage

// File: rtl/predec_opclass.sv
// Module: operand-shape lookup for one byte, in both opcode maps at once.
// Assumes the caller picks the map from the scan phase; the escape byte and
// prefixes are decided by the caller, not by the one-byte map.
module predec_opclass
    import predec_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic              is_prefix_o,
    output opcls_t            one_o,
    output opcls_t            two_o
);

    // Recognise the supported prefix bytes
    always_comb begin : prefix_match
        case (byte_i)
            8'h26, 8'h2E, 8'h36, 8'h3E,
            8'h64, 8'h65, 8'h66, 8'h67,
            8'hF0, 8'hF2, 8'hF3: is_prefix_o = 1'b1;
            default:             is_prefix_o = 1'b0;
        endcase
    end

    // Operand shape when the byte is a single-byte opcode
    always_comb begin : map_one
        one_o = '{modrm: 1'b0, imm: 3'd0, uops: 2'd1};
        if (byte_i < 8'h40) begin
            case (byte_i[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: one_o.modrm = 1'b1;
                3'd4:                   one_o.imm   = 3'd1;
                3'd5:                   one_o.imm   = 3'd4;
                default:                ;
            endcase
        end else begin
            case (byte_i)
                8'h80, 8'h83: one_o = '{modrm: 1'b1, imm: 3'd1, uops: 2'd2};
                8'h81:        one_o = '{modrm: 1'b1, imm: 3'd4, uops: 2'd2};
                8'h88, 8'h89,
                8'h8A, 8'h8B: one_o.modrm = 1'b1;
                8'hC3:        one_o.uops  = 2'd2;
                8'hCD:        one_o = '{modrm: 1'b0, imm: 3'd1, uops: 2'd3};
                8'hE8:        one_o = '{modrm: 1'b0, imm: 3'd4, uops: 2'd2};
                8'hE9:        one_o.imm   = 3'd4;
                8'hEB:        one_o.imm   = 3'd1;
                default: begin
                    if (byte_i[7:4] == 4'h7 || byte_i[7:3] == 5'b10110)
                        one_o.imm = 3'd1;
                    else if (byte_i[7:3] == 5'b10111)
                        one_o.imm = 3'd4;
                end
            endcase
        end
    end

    // Operand shape when the byte follows the escape
    always_comb begin : map_two
        two_o = '{modrm: 1'b1, imm: 3'd0, uops: 2'd1};
        if (byte_i[7:4] == 4'h8)
            two_o = '{modrm: 1'b0, imm: 3'd4, uops: 2'd1};
        else if (byte_i == 8'hA2)
            two_o = '{modrm: 1'b0, imm: 3'd0, uops: 2'd3};
        else if (byte_i == 8'hAF)
            two_o.uops = 2'd2;
    end

endmodule

// File: rtl/predec_lane.sv
// Module: one lane of the scan chain. Given the scan state left by the
// previous byte, it tags this byte and hands the updated state on.
// Assumes the class inputs come from predec_opclass for the same byte.
module predec_lane
    import predec_pkg::*;
(
    input  scan_t             cur_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              is_prefix_i,
    input  opcls_t            one_i,
    input  opcls_t            two_i,
    output scan_t             nxt_o,
    output tag_t              tag_o,
    output logic              over_o
);

    opcls_t            cls;
    logic              take_op;
    logic              done;
    logic [CNT_W-1:0]  disp;
    logic [CNT_W-1:0]  tail;

    // Displacement size from the ModRM mode field
    always_comb begin : disp_size
        case (byte_i[7:6])
            2'b01:   disp = CNT_W'(1);
            2'b10:   disp = CNT_W'(4);
            default: disp = '0;
        endcase
        tail = disp + CNT_W'(cur_i.imm);
    end

    // Advance the scan by one byte and form its tags
    always_comb begin : lane_step
        cls     = (cur_i.phase == PH_ESC) ? two_i : one_i;
        nxt_o   = cur_i;
        tag_o   = '0;
        take_op = 1'b0;
        done    = 1'b0;
        over_o  = 1'b0;
        tag_o.start = (cur_i.phase == PH_OPC) && (cur_i.len == '0);
        case (cur_i.phase)
            PH_OPC: begin
                if (byte_i == ESC_BYTE) begin
                    tag_o.opc   = 1'b1;
                    nxt_o.phase = PH_ESC;
                end else if (!is_prefix_i) begin
                    take_op = 1'b1;
                end
            end
            PH_ESC: take_op = 1'b1;
            PH_MODRM: begin
                if (tail == '0) begin
                    done = 1'b1;
                end else begin
                    nxt_o.phase = PH_TAIL;
                    nxt_o.rem   = tail;
                end
            end
            default: begin
                if (cur_i.rem == CNT_W'(1)) done = 1'b1;
                else nxt_o.rem = cur_i.rem - CNT_W'(1);
            end
        endcase
        if (take_op) begin
            tag_o.opc  = 1'b1;
            tag_o.uops = cls.uops;
            if (cls.modrm) begin
                nxt_o.phase = PH_MODRM;
                nxt_o.imm   = cls.imm;
            end else if (cls.imm != '0) begin
                nxt_o.phase = PH_TAIL;
                nxt_o.rem   = CNT_W'(cls.imm);
            end else begin
                done = 1'b1;
            end
        end
        if (!done && cur_i.len == LEN_W'(MAX_INSN - 1)) begin
            done   = 1'b1;
            over_o = 1'b1;
        end
        nxt_o.len = cur_i.len + LEN_W'(1);
        if (done) nxt_o = SCAN_IDLE;
        tag_o.fin = done;
    end

endmodule

// File: rtl/predec_annotator.sv
// Module: top of the predecode annotator. It chains LANES scan lanes
// combinationally across one window and registers the scan state left after
// the last lane for the next valid window.
// Assumes the bytes of a window are in stream order with lane 0 first.
module predec_annotator
    import predec_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_valid_i,
    input  logic                    restart_i,
    input  logic [LANES*BYTE_W-1:0] win_bytes_i,
    output logic [LANES-1:0]        start_o,
    output logic [LANES-1:0]        end_o,
    output logic [LANES-1:0]        opc_o,
    output logic [LANES*UOP_W-1:0]  uops_o,
    output logic [LANES-1:0]        overlong_o
);

    scan_t            chain [0:LANES];
    scan_t            st_q;
    tag_t             tags  [0:LANES-1];
    logic [LANES-1:0] cut;

    assign chain[0] = restart_i ? SCAN_IDLE : st_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic   pre;
        opcls_t c1;
        opcls_t c2;

        predec_opclass u_cls (
            .byte_i      (win_bytes_i[g*BYTE_W +: BYTE_W]),
            .is_prefix_o (pre),
            .one_o       (c1),
            .two_o       (c2)
        );

        predec_lane u_lane (
            .cur_i       (chain[g]),
            .byte_i      (win_bytes_i[g*BYTE_W +: BYTE_W]),
            .is_prefix_i (pre),
            .one_i       (c1),
            .two_i       (c2),
            .nxt_o       (chain[g+1]),
            .tag_o       (tags[g]),
            .over_o      (cut[g])
        );

        assign start_o[g]                = win_valid_i & tags[g].start;
        assign end_o[g]                  = win_valid_i & tags[g].fin;
        assign opc_o[g]                  = win_valid_i & tags[g].opc;
        assign uops_o[g*UOP_W +: UOP_W]  = win_valid_i ? tags[g].uops : '0;
        assign overlong_o[g]             = win_valid_i & cut[g];
    end

    // Keep the scan state of an unfinished instruction for the next window
    always_ff @(posedge clk) begin : scan_reg
        if (!rst_n)           st_q <= SCAN_IDLE;
        else if (win_valid_i) st_q <= chain[LANES];
    end

    // ---------------- assertions ----------------
    logic             last_end_q;
    logic [LANES-1:0] uop_nz;

    for (genvar g = 0; g < LANES; g++) begin : g_nz
        assign uop_nz[g] = |uops_o[g*UOP_W +: UOP_W];
    end

    // Remember whether the previous valid window closed its last instruction
    always_ff @(posedge clk) begin : chk_last_end
        if (!rst_n)           last_end_q <= 1'b1;
        else if (win_valid_i) last_end_q <= end_o[LANES-1];
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid_i |-> (start_o == '0 && end_o == '0 && opc_o == '0
                          && uops_o == '0 && overlong_o == '0));

    assert_start_follows_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_i |-> start_o[LANES-1:1] == end_o[LANES-2:0]);

    assert_uops_on_opcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_nz & ~opc_o) == '0);

    assert_carry_lane0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_i && !restart_i) |-> start_o[0] == last_end_q);

    assert_restart_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_i && restart_i) |-> start_o[0]);

    assert_overlong_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (overlong_o & ~end_o) == '0);

    assert_len_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.len <= LEN_W'(MAX_INSN - 1));

endmodule

// File: tb/sim_predec_annotator.sv
`timescale 1ns/1ps
module sim_predec_annotator;
    localparam int LN   = 16;
    localparam int MAXB = 4096;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            win_valid_i = 1'b0;
    logic            restart_i = 1'b0;
    logic [LN*8-1:0] win_bytes_i = '0;
    logic [LN-1:0]   start_o, end_o, opc_o, overlong_o;
    logic [LN*2-1:0] uops_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    logic [7:0] strm [0:MAXB+31];
    bit         es [0:MAXB-1];
    bit         ee [0:MAXB-1];
    bit         eo [0:MAXB-1];
    bit         ev [0:MAXB-1];
    logic [1:0] eu [0:MAXB-1];

    always #2 clk = ~clk;

    predec_annotator #(.LANES(LN)) u0 (
        .clk(clk), .rst_n(rst_n), .win_valid_i(win_valid_i), .restart_i(restart_i),
        .win_bytes_i(win_bytes_i), .start_o(start_o), .end_o(end_o), .opc_o(opc_o),
        .uops_o(uops_o), .overlong_o(overlong_o)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    // Reference tables, written from the requirements (R2, R6, R7)
    function automatic bit ref_pre(input logic [7:0] b);
        return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
                         8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3};
    endfunction

    function automatic void ref_one(input logic [7:0] b, output bit m, output int imm,
                                    output logic [1:0] u);
        m = 0; imm = 0; u = 2'd1;
        if (b < 8'h40) begin
            if (b[2:0] <= 3) m = 1;
            else if (b[2:0] == 4) imm = 1;
            else if (b[2:0] == 5) imm = 4;
        end
        else if (b == 8'h80 || b == 8'h83) begin m = 1; imm = 1; u = 2'd2; end
        else if (b == 8'h81) begin m = 1; imm = 4; u = 2'd2; end
        else if (b >= 8'h88 && b <= 8'h8B) m = 1;
        else if (b == 8'hC3) u = 2'd2;
        else if (b == 8'hCD) begin imm = 1; u = 2'd3; end
        else if (b == 8'hE8) begin imm = 4; u = 2'd2; end
        else if (b == 8'hE9) imm = 4;
        else if (b == 8'hEB || (b >= 8'h70 && b <= 8'h7F) || (b >= 8'hB0 && b <= 8'hB7)) imm = 1;
        else if (b >= 8'hB8 && b <= 8'hBF) imm = 4;
    endfunction

    function automatic void ref_two(input logic [7:0] b, output bit m, output int imm,
                                    output logic [1:0] u);
        m = 1; imm = 0; u = 2'd1;
        if (b >= 8'h80 && b <= 8'h8F) begin m = 0; imm = 4; end
        else if (b == 8'hA2) begin m = 0; u = 2'd3; end
        else if (b == 8'hAF) u = 2'd2;
    endfunction

    // Walk the stream instruction by instruction and fill the expected tags
    task automatic ref_walk(input int total);
        int p, q, o1, lastop, len, le, imm, disp;
        bit m, cut;
        logic [1:0] u;
        p = 0;
        while (p < total) begin
            q = p;
            while (q < p + 15 && ref_pre(strm[q])) q++;
            o1 = q;
            if (strm[q] == 8'h0F) begin lastop = q + 1; ref_two(strm[q+1], m, imm, u); end
            else begin lastop = q; ref_one(strm[q], m, imm, u); end
            disp = 0;
            if (m) begin
                if (strm[lastop+1][7:6] == 2'b01) disp = 1;
                else if (strm[lastop+1][7:6] == 2'b10) disp = 4;
            end
            len = (lastop - p + 1) + (m ? 1 : 0) + disp + imm;
            cut = (len > 15);
            le  = cut ? 15 : len;
            for (int k = p; k < p + le; k++) begin
                if (k < total) begin
                    es[k] = (k == p);
                    ee[k] = (k == p + le - 1);
                    eo[k] = (k >= o1 && k <= lastop);
                    eu[k] = (k == lastop) ? u : 2'd0;
                    ev[k] = cut && (k == p + le - 1);
                end
            end
            p += le;
        end
    endtask

    // One idle cycle: junk bytes and a stray restart must leave no trace
    task automatic idle_cycle();
        @(posedge clk); #1;
        win_valid_i = 1'b0;
        restart_i   = 1'($urandom);
        win_bytes_i = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        chk({start_o, end_o, opc_o, overlong_o}, 64'd0, "R1 idle flags");
        chk({32'd0, uops_o}, 64'd0, "R1 idle counts");
    endtask

    // Feed a stream (length a multiple of 16) and compare every window
    task automatic run(input int total, input int maxgap, input bit rs0, input string ctx);
        logic [LN-1:0]   xs, xe, xo, xv;
        logic [LN*2-1:0] xu;
        int base;
        for (int i = total; i < total + 32; i++) strm[i] = 8'h00;
        ref_walk(total);
        for (int w = 0; w < total / LN; w++) begin
            int gaps;
            gaps = (maxgap > 0) ? int'($urandom_range(0, maxgap)) : 0;
            for (int g = 0; g < gaps; g++) idle_cycle();
            base = w * LN;
            @(posedge clk); #1;
            win_valid_i = 1'b1;
            restart_i   = (w == 0) ? rs0 : 1'b0;
            for (int k = 0; k < LN; k++) begin
                win_bytes_i[k*8 +: 8] = strm[base+k];
                xs[k] = es[base+k]; xe[k] = ee[base+k]; xo[k] = eo[base+k];
                xv[k] = ev[base+k]; xu[k*2 +: 2] = eu[base+k];
            end
            @(negedge clk);
            chk({48'd0, start_o},    {48'd0, xs}, {"R3 start ", ctx});
            chk({48'd0, end_o},      {48'd0, xe}, {"R3 end ", ctx});
            chk({48'd0, opc_o},      {48'd0, xo}, {"R4 opcode ", ctx});
            chk({32'd0, uops_o},     {32'd0, xu}, {"R5 count ", ctx});
            chk({48'd0, overlong_o}, {48'd0, xv}, {"R11 overlong ", ctx});
        end
        @(posedge clk); #1;
        win_valid_i = 1'b0;
        restart_i   = 1'b0;
    endtask

    initial begin : main
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk({start_o, end_o, opc_o, overlong_o}, 64'd0, "R12 R1 reset outputs");
        chk({32'd0, uops_o}, 64'd0, "R12 R1 reset counts");

        // R12: first window after reset, no restart
        for (int i = 0; i < 32; i++) strm[i] = (i == 5) ? 8'hB8 : 8'h90;
        run(32, 0, 1'b0, "R12 first window after reset");

        // R6 R8: sweep every first byte, ModRM mode rotates with the opcode
        for (int op = 0; op < 256; op++) begin
            strm[0] = 8'(op);
            strm[1] = {2'(op), 6'h05};
            for (int i = 2; i < 16; i++) strm[i] = 8'h90;
            run(16, 0, 1'b1, "R6 R8 one-byte sweep");
        end

        // R7 R8: sweep every byte after the escape
        for (int op = 0; op < 256; op++) begin
            strm[0] = 8'h0F;
            strm[1] = 8'(op);
            strm[2] = {2'(op >> 2), 6'h0C};
            for (int i = 3; i < 16; i++) strm[i] = 8'h90;
            run(16, 0, 1'b1, "R7 R8 two-byte sweep");
        end

        // R2 R9: random bytes over many windows, with idle gaps
        for (int i = 0; i < 3200; i++) strm[i] = 8'($urandom);
        run(3200, 2, 1'b1, "R2 R9 random stream");

        // R2 R9: bytes drawn from a small prefix-rich set
        for (int i = 0; i < 1600; i++) begin
            case ($urandom_range(0, 7))
                0: strm[i] = 8'h66;  1: strm[i] = 8'hF3;  2: strm[i] = 8'h0F;
                3: strm[i] = 8'h81;  4: strm[i] = 8'h44;  5: strm[i] = 8'h90;
                6: strm[i] = 8'hB8;  default: strm[i] = 8'h84;
            endcase
        end
        run(1600, 1, 1'b1, "R2 R9 prefix-rich stream");

        // R11: 14 prefixes then a one-byte opcode is exactly legal
        for (int i = 0; i < 32; i++) strm[i] = (i < 14) ? 8'h66 : 8'h90;
        run(32, 0, 1'b1, "R11 fifteen-byte legal");

        // R11: 20 prefixes, cut at the 15th byte, inside one window
        for (int i = 0; i < 32; i++) strm[i] = (i < 20) ? 8'hF2 : 8'h90;
        run(32, 0, 1'b1, "R11 prefix run in window");

        // R11 R9: prefix run crossing a window edge, with gaps
        for (int i = 0; i < 48; i++) strm[i] = (i >= 10 && i < 30) ? 8'h3E : 8'h90;
        run(48, 2, 1'b1, "R11 R9 prefix run across windows");

        // R10: window ends inside an imm32, then a restart drops it
        for (int i = 0; i < 16; i++) strm[i] = (i == 15) ? 8'hB8 : 8'h90;
        run(16, 0, 1'b1, "R10 open tail before restart");
        idle_cycle();
        for (int i = 0; i < 16; i++) strm[i] = 8'hC3;
        run(16, 0, 1'b1, "R10 restart after open tail");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule